// File: doc/BRIEF.md
# Dual-Processor Mailbox and Interrupt Bridge

This block sits between a host processor and an auxiliary processor. Each direction has its own 8-bit one-way latch. The host writes the host-to-auxiliary latch through a write strobe and sees the auxiliary-to-host latch on a read bus. The auxiliary side reaches both latches through one 1 KiB address window at 0xE800-0xEBFF. A read there returns the host-to-auxiliary byte, and a write there loads the auxiliary-to-host byte. Reads have no strobe and no side effect, so they clear no interrupt and change no flag.

The block also makes the interrupts between the two processors. The host owns an interrupt-mask register. Mask bit 7 drives the auxiliary interrupt request directly. The host interrupt is armed when mask bit 4 and bit 3 of the auxiliary output port are both 1. It is raised as a held pulse that clears on the host acknowledge, and the acknowledge sees the vector byte 0xF0. On the auxiliary side, the auxiliary interrupt request passes through an edge detector with a selectable polarity. The detector sets a sticky request flag. A separate external request is cleared by any auxiliary write into the 0xEC00-0xEFFF window.

Top module: `mbox_bridge`

## Requirements
- R1: After reset, both latches, the mask register, the auxiliary port, both interrupt requests, the host pulse and both auxiliary request flags are 0.
- R2: A host mailbox write stores its byte. From the next cycle on, `aux_rdata_o` returns that byte whenever `aux_addr_i` is in 0xE800-0xEBFF. Outside that window `aux_rdata_o` is 0.
- R3: An auxiliary write with an address in 0xE800-0xEBFF stores its byte. From the next cycle on, `host_rdata_o` shows that byte.
- R4: An auxiliary write outside 0xE800-0xEBFF leaves the auxiliary-to-host latch unchanged. Placing addresses in the window with no write strobe (a read) clears no request.
- R5: `aux_irq_o` equals mask bit 7 from the cycle after a mask write. It changes at no other time.
- R6: The host pulse `host_irq_o` rises one cycle after (mask bit 4 AND port bit 3) becomes true. It stays high until a cycle with `host_ack_i` high and no new rising edge.
- R7: After an acknowledge, `host_irq_o` stays low while the condition remains true. It re-arms only after the condition goes false and then true again.
- R8: `host_vec_o` is 0xF0 while `host_ack_i` is high, and 0x00 otherwise.
- R9: If a rising edge of the host condition and `host_ack_i` fall in the same cycle, the pulse is set (set wins).
- R10: `aux_ext_req_i` sets `aux_ext_irq_o` on the next cycle. Any auxiliary write into 0xEC00-0xEFFF clears it. A write to any other address does not clear it. A set in the same cycle as a clear wins.
- R11: With `aux_edge_rise_i`=1, a 0 to 1 change of `aux_irq_o` sets `aux_edge_flag_o` one cycle later. With it 0, a 1 to 0 change sets the flag instead. The opposite edge does nothing.
- R12: `aux_edge_flag_o` stays set until `aux_edge_clr_i`. If a detected edge and the clear fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_wdata_i | input | 8 | Host write data |
| host_mbox_we_i | input | 1 | Host write to host-to-auxiliary latch |
| host_mask_we_i | input | 1 | Host write to mask register |
| host_rdata_o | output | 8 | Auxiliary-to-host latch contents |
| host_ack_i | input | 1 | Host interrupt acknowledge cycle |
| host_irq_o | output | 1 | Host interrupt pulse |
| host_vec_o | output | 8 | Vector byte during acknowledge |
| aux_addr_i | input | 16 | Auxiliary address |
| aux_we_i | input | 1 | Auxiliary write strobe |
| aux_wdata_i | input | 8 | Auxiliary write data |
| aux_rdata_o | output | 8 | Host-to-auxiliary latch when in window, else 0 |
| aux_port_we_i | input | 1 | Auxiliary output-port write |
| aux_port_d_i | input | 8 | Auxiliary output-port data |
| aux_port_o | output | 8 | Auxiliary output port |
| aux_ext_req_i | input | 1 | External request set to auxiliary side |
| aux_ext_irq_o | output | 1 | External request flag |
| aux_edge_rise_i | input | 1 | Edge polarity select (1 rising, 0 falling) |
| aux_edge_clr_i | input | 1 | Clear of the edge request flag |
| aux_irq_o | output | 1 | Auxiliary interrupt request (mask bit 7) |
| aux_edge_flag_o | output | 1 | Edge-detected request flag |

## Verification
Three pairs of functions can land in the same cycle: the rising edge of the host condition and the host acknowledge, a detected edge and the flag clear, and the external request and the acknowledge-window write. The bench times the port write and the acknowledge so that the one-cycle rising edge coincides with `host_ack_i`. It times the flag clear to the cycle right after a mask write, and it drives the external request together with an 0xEC00-window write. In each case it judges the set-wins result one cycle later. The latches are swept over all 256 byte values in both directions.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned BYTE_W = 8;

  function automatic logic win_hit(input logic [15:0] addr, input logic [15:0] base,
                                   input int unsigned win_bits);
    return (addr >> win_bits) == (base >> win_bits);
  endfunction
endpackage

// File: rtl/mbox_reg.sv
module mbox_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(we_i) |-> $stable(q_o)); // R4
endmodule

// File: rtl/host_pulse.sv
module host_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  input  logic ack_i,
  output logic irq_o
);
  logic cond_q;
  logic rise;

  assign rise = cond_i & ~cond_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      cond_q <= cond_i;
      if (rise)       irq_o <= 1'b1;  // set wins over ack
      else if (ack_i) irq_o <= 1'b0;
    end
  end

  AST_PULSE_DROP_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(ack_i)); // R6
  AST_PULSE_RISE_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(cond_i)); // R7
  AST_SET_BEATS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && ack_i) |=> irq_o); // R9
endmodule

// File: rtl/edge_flag.sv
module edge_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic rise_sel_i,
  input  logic clr_i,
  output logic flag_o
);
  logic sig_q;
  logic hit;

  assign hit = rise_sel_i ? (sig_i & ~sig_q) : (~sig_i & sig_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_q  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      sig_q <= sig_i;
      if (hit)        flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end

  AST_FLAG_SET_BY_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(sig_i != sig_q)); // R11
  AST_FLAG_CLR_BY_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(clr_i)); // R12
endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
  import mbox_pkg::*;
#(
  parameter int unsigned  DW        = BYTE_W,
  parameter int unsigned  AW        = 16,
  parameter int unsigned  WIN_BITS  = 10,
  parameter logic [15:0]  MBOX_BASE = 16'hE800,
  parameter logic [15:0]  ACK_BASE  = 16'hEC00,
  parameter logic [7:0]   VECTOR    = 8'hF0,
  parameter int unsigned  AUX_BIT   = 7,
  parameter int unsigned  HOST_BIT  = 4,
  parameter int unsigned  GATE_BIT  = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] host_wdata_i,
  input  logic          host_mbox_we_i,
  input  logic          host_mask_we_i,
  output logic [DW-1:0] host_rdata_o,
  input  logic          host_ack_i,
  output logic          host_irq_o,
  output logic [7:0]    host_vec_o,
  input  logic [AW-1:0] aux_addr_i,
  input  logic          aux_we_i,
  input  logic [DW-1:0] aux_wdata_i,
  output logic [DW-1:0] aux_rdata_o,
  input  logic          aux_port_we_i,
  input  logic [DW-1:0] aux_port_d_i,
  output logic [DW-1:0] aux_port_o,
  input  logic          aux_ext_req_i,
  output logic          aux_ext_irq_o,
  input  logic          aux_edge_rise_i,
  input  logic          aux_edge_clr_i,
  output logic          aux_irq_o,
  output logic          aux_edge_flag_o
);
  localparam int unsigned NLATCH = 2;  // 0: host->aux, 1: aux->host

  logic [DW-1:0] mask_q;
  logic          in_mbox, in_ack, host_cond;
  logic          lat_we [NLATCH];
  logic [DW-1:0] lat_d  [NLATCH];
  logic [DW-1:0] lat_q  [NLATCH];

  assign in_mbox = win_hit(16'(aux_addr_i), MBOX_BASE, WIN_BITS);
  assign in_ack  = win_hit(16'(aux_addr_i), ACK_BASE, WIN_BITS);

  assign lat_we[0] = host_mbox_we_i;
  assign lat_d[0]  = host_wdata_i;
  assign lat_we[1] = aux_we_i & in_mbox;
  assign lat_d[1]  = aux_wdata_i;

  for (genvar g = 0; g < NLATCH; g++) begin : g_latch
    mbox_reg #(.W(DW)) u_lat (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(lat_we[g]), .d_i(lat_d[g]), .q_o(lat_q[g])
    );
  end

  mbox_reg #(.W(DW)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(host_mask_we_i), .d_i(host_wdata_i), .q_o(mask_q)
  );

  mbox_reg #(.W(DW)) u_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(aux_port_we_i), .d_i(aux_port_d_i), .q_o(aux_port_o)
  );

  assign aux_rdata_o  = in_mbox ? lat_q[0] : '0;
  assign host_rdata_o = lat_q[1];
  assign aux_irq_o    = mask_q[AUX_BIT];
  assign host_cond    = mask_q[HOST_BIT] & aux_port_o[GATE_BIT];
  assign host_vec_o   = host_ack_i ? VECTOR : 8'h00;

  host_pulse u_host_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(host_cond), .ack_i(host_ack_i), .irq_o(host_irq_o)
  );

  edge_flag u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(aux_irq_o), .rise_sel_i(aux_edge_rise_i),
    .clr_i(aux_edge_clr_i), .flag_o(aux_edge_flag_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 aux_ext_irq_o <= 1'b0;
    else if (aux_ext_req_i)      aux_ext_irq_o <= 1'b1;
    else if (aux_we_i && in_ack) aux_ext_irq_o <= 1'b0;
  end

  AST_AUX_IRQ_ON_MASK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(host_mask_we_i) |-> $stable(aux_irq_o)); // R5
  AST_EXT_CLR_BY_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(aux_ext_irq_o) |-> $past(aux_we_i && in_ack)); // R10
  AST_HOST_LATCH_AUX_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(aux_we_i) |-> $stable(host_rdata_o)); // R3
endmodule

// File: tb/mbox_bridge_test.sv
module mbox_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic        host_mbox_we = 1'b0, host_mask_we = 1'b0, host_ack = 1'b0;
  logic [7:0]  host_rdata, host_vec;
  logic        host_irq;
  logic [15:0] aux_addr = '0;
  logic        aux_we = 1'b0;
  logic [7:0]  aux_wdata = '0, aux_rdata;
  logic        aux_port_we = 1'b0;
  logic [7:0]  aux_port_d = '0, aux_port;
  logic        aux_ext_req = 1'b0, aux_ext_irq;
  logic        aux_edge_rise = 1'b1, aux_edge_clr = 1'b0;
  logic        aux_irq, aux_edge_flag;

  int nvec = 0;
  int nerr = 0;
  int cyc  = 0;

  always #10 clk = ~clk;  // 50 MHz

  mbox_bridge uut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_wdata_i(host_wdata), .host_mbox_we_i(host_mbox_we), .host_mask_we_i(host_mask_we),
    .host_rdata_o(host_rdata), .host_ack_i(host_ack), .host_irq_o(host_irq),
    .host_vec_o(host_vec), .aux_addr_i(aux_addr), .aux_we_i(aux_we),
    .aux_wdata_i(aux_wdata), .aux_rdata_o(aux_rdata), .aux_port_we_i(aux_port_we),
    .aux_port_d_i(aux_port_d), .aux_port_o(aux_port), .aux_ext_req_i(aux_ext_req),
    .aux_ext_irq_o(aux_ext_irq), .aux_edge_rise_i(aux_edge_rise),
    .aux_edge_clr_i(aux_edge_clr), .aux_irq_o(aux_irq), .aux_edge_flag_o(aux_edge_flag)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic host_mask(input logic [7:0] d);
    host_wdata = d; host_mask_we = 1'b1; tick(); host_mask_we = 1'b0;
  endtask

  task automatic port_wr(input logic [7:0] d);
    aux_port_d = d; aux_port_we = 1'b1; tick(); aux_port_we = 1'b0;
  endtask

  task automatic aux_wr(input logic [15:0] a, input logic [7:0] d);
    aux_addr = a; aux_wdata = d; aux_we = 1'b1; tick(); aux_we = 1'b0;
  endtask

  initial begin
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    nerr++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    tick(); tick();
    // R1 reset state
    chk("R1 host_rdata", host_rdata, 8'h00);
    aux_addr = 16'hE800; #1;
    chk("R1 aux_rdata", aux_rdata, 8'h00);
    chk("R1 port", aux_port, 8'h00);
    chk("R1 irqs", {3'b0, host_irq, aux_irq, aux_ext_irq, aux_edge_flag, 1'b0}, 8'h00);
    rst_n = 1'b1;
    tick();

    // R2/R3 exhaustive latch sweeps
    for (int i = 0; i < 256; i++) begin
      host_wdata = 8'(i); host_mbox_we = 1'b1; tick(); host_mbox_we = 1'b0;
      aux_addr = 16'hE800 | 16'((i * 37) & 16'h3FF); #1;
      chk("R2 window read", aux_rdata, 8'(i));
      aux_addr = 16'hE7FF; #1;
      chk("R2 outside window", aux_rdata, 8'h00);
      aux_wr(16'hE800 | 16'((i * 91) & 16'h3FF), 8'(255 - i));
      chk("R3 aux to host", host_rdata, 8'(255 - i));
      aux_wr((i % 2) ? 16'hE7FF : 16'hEC00, 8'(i));
      chk("R4 out-of-window write ignored", host_rdata, 8'(255 - i));
    end

    // R5 aux irq follows mask bit 7; R11 rising polarity
    aux_edge_rise = 1'b1;
    aux_ext_req = 1'b0;
    host_mask(8'h80);
    chk("R5 aux_irq set", {7'b0, aux_irq}, 8'h01);
    chk("R11 flag not yet", {7'b0, aux_edge_flag}, 8'h00);
    tick();
    chk("R11 rise sets flag", {7'b0, aux_edge_flag}, 8'h01);
    aux_edge_clr = 1'b1; tick(); aux_edge_clr = 1'b0;
    chk("R12 clear", {7'b0, aux_edge_flag}, 8'h00);
    host_mask(8'h00);
    chk("R5 aux_irq clear", {7'b0, aux_irq}, 8'h00);
    tick();
    chk("R11 fall ignored when rising", {7'b0, aux_edge_flag}, 8'h00);
    // R11 falling polarity
    aux_edge_rise = 1'b0;
    host_mask(8'h80); tick();
    chk("R11 rise ignored when falling", {7'b0, aux_edge_flag}, 8'h00);
    host_mask(8'h00); tick();
    chk("R11 fall sets flag", {7'b0, aux_edge_flag}, 8'h01);
    // R4 read in window does not clear anything
    aux_addr = 16'hE900; tick(); tick();
    chk("R4 read no side effect", {7'b0, aux_edge_flag}, 8'h01);
    aux_edge_clr = 1'b1; tick(); aux_edge_clr = 1'b0;
    // R12 edge and clear in the same cycle
    aux_edge_rise = 1'b1;
    host_mask(8'h80);
    aux_edge_clr = 1'b1; tick(); aux_edge_clr = 1'b0;
    chk("R12 edge beats clear", {7'b0, aux_edge_flag}, 8'h01);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R5 aux_irq stable", {7'b0, aux_irq}, 8'h01);
    end
    host_mask(8'h00);
    aux_edge_clr = 1'b1; tick(); aux_edge_clr = 1'b0;

    // R6/R7/R8/R9 host pulse, sweep of gating combinations
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 2; p++) begin
        host_mask(m ? 8'h10 : 8'h00);
        port_wr(p ? 8'h08 : 8'hF7);
        tick();
        chk("R6 gate AND", {7'b0, host_irq}, 8'((m & p)));
        host_ack = 1'b1; #1;
        chk("R8 vector on ack", host_vec, 8'hF0);
        tick(); host_ack = 1'b0; #1;
        chk("R8 vector idle", host_vec, 8'h00);
        chk("R6 cleared by ack", {7'b0, host_irq}, 8'h00);
        tick(); tick();
        chk("R7 no rearm while true", {7'b0, host_irq}, 8'h00);
        port_wr(8'h00); host_mask(8'h00);
      end
    end
    host_mask(8'h10);
    port_wr(8'h08);
    chk("R6 one-cycle latency", {7'b0, host_irq}, 8'h00);
    tick();
    chk("R6 pulse raised", {7'b0, host_irq}, 8'h01);
    port_wr(8'h00); tick();
    chk("R6 held without ack", {7'b0, host_irq}, 8'h01);
    // R9 rise coincides with ack while still pending
    port_wr(8'h08);
    host_ack = 1'b1; tick(); host_ack = 1'b0;
    chk("R9 set beats ack", {7'b0, host_irq}, 8'h01);
    host_ack = 1'b1; tick(); host_ack = 1'b0;
    chk("R9 later ack clears", {7'b0, host_irq}, 8'h00);
    port_wr(8'h00); host_mask(8'h00);

    // R10 external request and window clear
    aux_ext_req = 1'b1; tick(); aux_ext_req = 1'b0;
    chk("R10 set", {7'b0, aux_ext_irq}, 8'h01);
    aux_wr(16'hF000, 8'h00);
    chk("R10 other addr ignored", {7'b0, aux_ext_irq}, 8'h01);
    aux_wr(16'hEFFF, 8'h00);
    chk("R10 cleared", {7'b0, aux_ext_irq}, 8'h00);
    aux_ext_req = 1'b1; aux_wr(16'hEC00, 8'h00); aux_ext_req = 1'b0;
    chk("R10 set beats clear", {7'b0, aux_ext_irq}, 8'h01);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule